// File: doc/BRIEF.md
# CCD Horizontal Line Timing Generator

This block produces every timing signal an interline CCD needs within one horizontal line. It runs from one pixel-rate clock. A position counter runs from 1 to the line length and wraps back to 1. All outputs are registered decodes of that position. The output for counter value p appears one clock after the counter holds p. In this document, "position p" means that output cycle.

Near the start of each line, the block raises a line sync pulse. During blanking it moves the vertical gates through a shift sequence, with every gate edge on a fixed 40-clock grid. The horizontal register is read out only after the vertical gates have returned to rest. During readout the horizontal phase pins, the reset-gate pin and three segment flags show which sample leaves the register in each clock: prescan dummy, optical black or effective pixel.

The horizontal phase pins and the reset-gate pin carry, per clock, the level that the pin takes in the first half of that clock. An output driver flips `hclk1`/`hclk2` in the second half and ends the reset-gate pulse there. One sample therefore leaves per clock, and the reset gate fires once per sample, ahead of its charge. The two-bit transfer-mode input selects one of three vertical patterns: standard, double or triple line transfer. The block samples this input only when the counter wraps.

Top module: `ccd_htg_top`

## Requirements
- R1: `hsync` is high for positions 1 to 227 and low for positions 228 to 2280. The line repeats every 2280 clocks.
- R2: Window positions 540 to 2271 carry 1732 samples. `seg_prescan` marks 540–567. `seg_black` marks 568–569 and 2220–2271. `seg_active` marks 570–2219. No flag is high outside the window, and at most one flag is high at any time.
- R3: `hclk1` and `hclk2` are always complementary. Inside the window `hclk1`=1. Outside it `hclk1`=0 and `hclk2`=1, held static.
- R4: `rgate` is high in exactly the window positions, so there is one reset pulse per output sample.
- R5: Bit mapping of `vclk` is [0]=gate 1A, [1]=gate 1B, [2]=gate 2, [3]=gate 3A, [4]=gate 3B, [5]=gate 4. At rest, gates 1 and 2 are high (`vclk`=6'b000111). The gates are at rest at positions below 52 and after the last edge of the line, and always while `hclk1`=1.
- R6: Standard transfer (mode 2'b00) has 8 edges at positions 52+40k, k=0..7. The gate sets after each edge are {2}, {2,3}, {3}, {3,4}, {4}, {4,1}, {1}, {1,2}.
- R7: Double transfer (mode 2'b01) has 8 edges at 52+40k. The gate sets cycle through {2,3}, {3,4}, {4,1}, {1,2} twice.
- R8: Triple transfer (mode 2'b10) has 12 edges at 52+40k, k=0..11. The gate sets cycle through the same four pairs three times.
- R9: Between edges `vclk` stays stable for at least 40 clocks. One or two gates are high at any time, and two high gates are always neighbours in the cycle 1-2-3-4-1.
- R10: The mode is captured only as the counter wraps from 2280 to 1. A change during a line does not alter that line's pattern. Mode 2'b11 behaves as standard.
- R11: During reset, `hsync`, `rgate` and all flags are 0, `hclk1`=0, `hclk2`=1 and `vclk` is at rest.
- R12: `vclk[0]` always equals `vclk[1]`, and `vclk[3]` always equals `vclk[4]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_mode | input | 2 | Vertical transfer mode: 00 standard, 01 double, 10 triple, 11 standard |
| hsync | output | 1 | Line sync pulse |
| hclk1 | output | 1 | Horizontal phase 1, first-half level |
| hclk2 | output | 1 | Horizontal phase 2, first-half level |
| rgate | output | 1 | Reset-gate pulse request, one per sample |
| seg_prescan | output | 1 | Current sample is a prescan dummy |
| seg_black | output | 1 | Current sample is optical black |
| seg_active | output | 1 | Current sample is an effective pixel |
| vclk | output | 6 | Vertical gate levels: 1A, 1B, 2, 3A, 3B, 4 from bit 0 |

## Verification
A wrong counter or wrap value moves the `hsync` rise away from its 2280-clock period. Such a fault also shifts the window flags and the vertical edges at the same time, so it shows within one line. A wrong step count or a wrong mode capture gives a gate set that differs from the one expected for that mode. This shows at the first affected 40-clock edge, and within one line of a mid-line mode change. Faults in the window decode show as a wrong flag, or as a horizontal phase that moves, at one of the boundaries 540, 568, 570, 2220 or 2272.

// File: rtl/ccd_htg_pkg.sv
package ccd_htg_pkg;

  typedef enum logic [1:0] {
    XFER_STD = 2'b00,
    XFER_DBL = 2'b01,
    XFER_TRI = 2'b10
  } xfer_e;

  localparam int STEP_W    = 4;
  localparam int STD_EDGES = 8;
  localparam int DBL_EDGES = 8;
  localparam int TRI_EDGES = 12;

  // Gate group vector {g4, g3, g2, g1}; rest state has g1 and g2 high.
  localparam logic [3:0] GRP_REST = 4'b0011;

  function automatic xfer_e decode_mode(input logic [1:0] raw);
    case (raw)
      2'b01:   return XFER_DBL;
      2'b10:   return XFER_TRI;
      default: return XFER_STD;
    endcase
  endfunction

  function automatic logic [STEP_W-1:0] edges_for(input xfer_e m);
    case (m)
      XFER_DBL: return STEP_W'(DBL_EDGES);
      XFER_TRI: return STEP_W'(TRI_EDGES);
      default:  return STEP_W'(STD_EDGES);
    endcase
  endfunction

  // Group levels after st edges of the line.
  function automatic logic [3:0] grp_pattern(input xfer_e m, input logic [STEP_W-1:0] st);
    logic [3:0] g;
    if (m == XFER_STD) begin
      case (st)
        4'd1:    g = 4'b0010;
        4'd2:    g = 4'b0110;
        4'd3:    g = 4'b0100;
        4'd4:    g = 4'b1100;
        4'd5:    g = 4'b1000;
        4'd6:    g = 4'b1001;
        4'd7:    g = 4'b0001;
        default: g = GRP_REST;
      endcase
    end else begin
      case (st[1:0])
        2'd1:    g = 4'b0110;
        2'd2:    g = 4'b1100;
        2'd3:    g = 4'b1001;
        default: g = GRP_REST;
      endcase
    end
    return g;
  endfunction

  // Pin order: [0]=1A [1]=1B [2]=2 [3]=3A [4]=3B [5]=4
  function automatic logic [5:0] grp_to_pins(input logic [3:0] g);
    return {g[3], g[2], g[2], g[1], g[0], g[0]};
  endfunction

endpackage

// File: rtl/ccd_htg_counter.sv
module ccd_htg_counter #(
  parameter int LINE_LEN = 2280,
  parameter int CW       = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  localparam logic [CW-1:0] LAST = CW'(LINE_LEN);
  localparam logic [CW-1:0] ONE  = CW'(1);

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= LAST;
    else if (wrap) cnt <= ONE;
    else cnt <= cnt + ONE;
  end
endmodule

// File: rtl/ccd_htg_hseg.sv
module ccd_htg_hseg #(
  parameter int CW        = 12,
  parameter int HSYNC_END = 228,
  parameter int WIN_START = 540,
  parameter int PRESCAN   = 28,
  parameter int FRONT_OB  = 2,
  parameter int ACTIVE    = 1650,
  parameter int REAR_OB   = 52
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  output logic          hsync,
  output logic          hclk1,
  output logic          hclk2,
  output logic          rgate,
  output logic          seg_prescan,
  output logic          seg_black,
  output logic          seg_active
);
  localparam logic [CW-1:0] HS_END  = CW'(HSYNC_END);
  localparam logic [CW-1:0] W_BEGIN = CW'(WIN_START);
  localparam logic [CW-1:0] PRE_END = CW'(WIN_START + PRESCAN);
  localparam logic [CW-1:0] FOB_END = CW'(WIN_START + PRESCAN + FRONT_OB);
  localparam logic [CW-1:0] ACT_END = CW'(WIN_START + PRESCAN + FRONT_OB + ACTIVE);
  localparam logic [CW-1:0] W_END   = CW'(WIN_START + PRESCAN + FRONT_OB + ACTIVE + REAR_OB);

  logic pre_d, blk_d, act_d, win_d;

  always_comb begin
    pre_d = (cnt >= W_BEGIN) && (cnt < PRE_END);
    blk_d = ((cnt >= PRE_END) && (cnt < FOB_END)) ||
            ((cnt >= ACT_END) && (cnt < W_END));
    act_d = (cnt >= FOB_END) && (cnt < ACT_END);
    win_d = pre_d | blk_d | act_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync       <= 1'b0;
      hclk1       <= 1'b0;
      hclk2       <= 1'b1;
      rgate       <= 1'b0;
      seg_prescan <= 1'b0;
      seg_black   <= 1'b0;
      seg_active  <= 1'b0;
    end else begin
      hsync       <= (cnt < HS_END);
      hclk1       <= win_d;
      hclk2       <= ~win_d;
      rgate       <= win_d;
      seg_prescan <= pre_d;
      seg_black   <= blk_d;
      seg_active  <= act_d;
    end
  end
endmodule

// File: rtl/ccd_htg_vseq.sv
module ccd_htg_vseq
  import ccd_htg_pkg::*;
#(
  parameter int CW          = 12,
  parameter int VEDGE_FIRST = 52,
  parameter int VEDGE_STEP  = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          wrap,
  input  logic [1:0]    xfer_mode,
  output logic [5:0]    vclk
);
  localparam logic [CW-1:0] FIRST = CW'(VEDGE_FIRST);
  localparam logic [CW-1:0] STEP  = CW'(VEDGE_STEP);

  xfer_e             mode_q;
  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] step_upd;
  logic [CW-1:0]     next_edge;
  logic              hit;

  always_comb begin
    hit      = (cnt == next_edge) && (step < edges_for(mode_q));
    step_upd = hit ? step + STEP_W'(1) : step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= XFER_STD;
      step      <= '0;
      next_edge <= FIRST;
      vclk      <= grp_to_pins(GRP_REST);
    end else begin
      vclk <= grp_to_pins(grp_pattern(mode_q, step_upd));
      if (wrap) begin
        mode_q    <= decode_mode(xfer_mode);
        step      <= '0;
        next_edge <= FIRST;
      end else if (hit) begin
        step      <= step_upd;
        next_edge <= next_edge + STEP;
      end
    end
  end
endmodule

// File: rtl/ccd_htg_top.sv
module ccd_htg_top #(
  parameter int LINE_LEN    = 2280,
  parameter int HSYNC_END   = 228,
  parameter int WIN_START   = 540,
  parameter int PRESCAN     = 28,
  parameter int FRONT_OB    = 2,
  parameter int ACTIVE      = 1650,
  parameter int REAR_OB     = 52,
  parameter int VEDGE_FIRST = 52,
  parameter int VEDGE_STEP  = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] xfer_mode,
  output logic       hsync,
  output logic       hclk1,
  output logic       hclk2,
  output logic       rgate,
  output logic       seg_prescan,
  output logic       seg_black,
  output logic       seg_active,
  output logic [5:0] vclk
);
  localparam int CW = $clog2(LINE_LEN + 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  ccd_htg_counter #(.LINE_LEN(LINE_LEN), .CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .wrap(wrap)
  );

  ccd_htg_hseg #(
    .CW(CW), .HSYNC_END(HSYNC_END), .WIN_START(WIN_START), .PRESCAN(PRESCAN),
    .FRONT_OB(FRONT_OB), .ACTIVE(ACTIVE), .REAR_OB(REAR_OB)
  ) u_hseg (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .hsync(hsync), .hclk1(hclk1),
    .hclk2(hclk2), .rgate(rgate), .seg_prescan(seg_prescan),
    .seg_black(seg_black), .seg_active(seg_active)
  );

  ccd_htg_vseq #(.CW(CW), .VEDGE_FIRST(VEDGE_FIRST), .VEDGE_STEP(VEDGE_STEP)) u_vseq (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .wrap(wrap), .xfer_mode(xfer_mode), .vclk(vclk)
  );
endmodule

// File: rtl/ccd_htg_chk.sv
module ccd_htg_chk #(
  parameter int LINE_LEN   = 2280,
  parameter int HSYNC_END  = 228,
  parameter int VEDGE_STEP = 40
) (
  input logic       clk,
  input logic       rst_n,
  input logic       hsync,
  input logic       hclk1,
  input logic       hclk2,
  input logic       rgate,
  input logic       seg_prescan,
  input logic       seg_black,
  input logic       seg_active,
  input logic [5:0] vclk
);
  localparam int KW = $clog2(LINE_LEN + 1);
  localparam logic [KW-1:0] HS_LEN  = KW'(HSYNC_END - 1);
  localparam logic [KW-1:0] MIN_RUN = KW'(VEDGE_STEP);
  localparam logic [KW-1:0] SAT     = {KW{1'b1}};

  logic [KW-1:0] hs_run, v_run;
  logic          hs_prev;
  logic [5:0]    v_prev;
  logic [3:0]    grp;

  assign grp = {vclk[5], vclk[3], vclk[2], vclk[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_run  <= '0;
      hs_prev <= 1'b0;
      v_prev  <= 6'b000111;
      v_run   <= SAT;
    end else begin
      hs_prev <= hsync;
      hs_run  <= hsync ? hs_run + KW'(1) : '0;
      v_prev  <= vclk;
      if (vclk != v_prev) v_run <= KW'(1);
      else if (v_run != SAT) v_run <= v_run + KW'(1);
    end
  end

  assert_hsync_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_prev && !hsync) |-> (hs_run == HS_LEN));
  assert_seg_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({seg_prescan, seg_black, seg_active}));
  assert_hclk_compl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hclk1 != hclk2);
  assert_rgate_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rgate == (seg_prescan | seg_black | seg_active));
  assert_vrest_readout_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hclk1 |-> (vclk == 6'b000111));
  assert_vgate_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(grp) >= 1) && ($countones(grp) <= 2) &&
    !(grp[0] && grp[2]) && !(grp[1] && grp[3]));
  assert_vmin_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vclk != v_prev) |-> (v_run >= MIN_RUN));
  assert_vpairs_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (vclk[0] == vclk[1]) && (vclk[3] == vclk[4]));
endmodule

bind ccd_htg_top ccd_htg_chk #(
  .LINE_LEN(LINE_LEN), .HSYNC_END(HSYNC_END), .VEDGE_STEP(VEDGE_STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hsync(hsync), .hclk1(hclk1), .hclk2(hclk2),
  .rgate(rgate), .seg_prescan(seg_prescan), .seg_black(seg_black),
  .seg_active(seg_active), .vclk(vclk)
);

// File: tb/tb_ccd_htg_top.sv
module tb_ccd_htg_top;
  localparam int L     = 2280;
  localparam int HS    = 228;
  localparam int WS    = 540;
  localparam int E0    = 52;
  localparam int ESTEP = 40;
  localparam logic [5:0] REST = 6'b000111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] xfer_mode = 2'b00;
  logic hsync, hclk1, hclk2, rgate, seg_prescan, seg_black, seg_active;
  logic [5:0] vclk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ccd_htg_top dut (
    .clk(clk), .rst_n(rst_n), .xfer_mode(xfer_mode), .hsync(hsync),
    .hclk1(hclk1), .hclk2(hclk2), .rgate(rgate), .seg_prescan(seg_prescan),
    .seg_black(seg_black), .seg_active(seg_active), .vclk(vclk)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected gate levels: mode 0 standard, 1 double, 2 triple.
  function automatic logic [5:0] exp_v(input int mode, input int p);
    int n, k;
    logic [3:0] g;
    n = (mode == 2) ? 12 : 8;
    k = (p < E0) ? 0 : ((p - E0) / ESTEP + 1);
    if (k > n) k = n;
    if (mode == 0) begin
      case (k)
        1: g = 4'b0010; 2: g = 4'b0110; 3: g = 4'b0100; 4: g = 4'b1100;
        5: g = 4'b1000; 6: g = 4'b1001; 7: g = 4'b0001; default: g = 4'b0011;
      endcase
    end else begin
      case (k % 4)
        1: g = 4'b0110; 2: g = 4'b1100; 3: g = 4'b1001; default: g = 4'b0011;
      endcase
    end
    return {g[3], g[2], g[2], g[1], g[0], g[0]};
  endfunction

  // Checks one full line starting at position 1 at the current negedge.
  task automatic check_line(input int mode, input string vreq,
                            input logic [1:0] new_raw, input int change_at);
    int e1 = 0, e2 = 0, e3 = 0, e4 = 0, ev = 0, er = 0, e9 = 0, e12 = 0;
    int a1 = 0, x1 = 0, a2 = 0, x2 = 0, a3 = 0, x3 = 0, a4 = 0, x4 = 0;
    int av = 0, xv = 0, ar = 0, xr = 0, gap = 0, last_chg = -1000;
    logic [5:0] prev_v = REST;
    for (int p = 1; p <= L; p++) begin
      logic ex_pre, ex_blk, ex_act, ex_win;
      logic [5:0] xvc;
      ex_pre = (p >= 540) && (p < 568);
      ex_blk = ((p >= 568) && (p < 570)) || ((p >= 2220) && (p < 2272));
      ex_act = (p >= 570) && (p < 2220);
      ex_win = ex_pre | ex_blk | ex_act;
      xvc = exp_v(mode, p);
      if (hsync !== (p < HS) && e1 == 0) begin e1 = 1; a1 = hsync; x1 = p; end
      if ({seg_prescan, seg_black, seg_active} !== {ex_pre, ex_blk, ex_act} && e2 == 0) begin
        e2 = 1; a2 = {seg_prescan, seg_black, seg_active}; x2 = {ex_pre, ex_blk, ex_act};
      end
      if ({hclk1, hclk2} !== {ex_win, ~ex_win} && e3 == 0) begin
        e3 = 1; a3 = {hclk1, hclk2}; x3 = {ex_win, ~ex_win};
      end
      if (rgate !== ex_win && e4 == 0) begin e4 = 1; a4 = rgate; x4 = p; end
      if (vclk !== xvc) begin
        if (p < E0 || p >= WS) begin
          if (er == 0) begin er = 1; ar = vclk; xr = xvc; end
        end else if (ev == 0) begin ev = 1; av = vclk; xv = xvc; end
      end
      if (vclk !== prev_v) begin
        if (p - last_chg < ESTEP && e9 == 0) begin e9 = 1; gap = p - last_chg; end
        last_chg = p;
      end
      prev_v = vclk;
      if ((vclk[0] !== vclk[1]) || (vclk[3] !== vclk[4])) e12 = 1;
      if (p == change_at) xfer_mode = new_raw;
      @(negedge clk);
    end
    chk(e1 == 0, "R1", "hsync vs position", a1, x1);
    chk(e2 == 0, "R2", "segment flags", a2, x2);
    chk(e3 == 0, "R3", "hclk1/hclk2", a3, x3);
    chk(e4 == 0, "R4", "rgate at position", a4, x4);
    chk(er == 0, "R5", "vclk at rest", ar, xr);
    chk(ev == 0, vreq, "vclk pattern", av, xv);
    chk(e9 == 0, "R9", "edge spacing", gap, ESTEP);
    chk(e12 == 0, "R12", "pair equality", e12, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(hsync == 1'b0, "R11", "hsync in reset", hsync, 0);
    chk({seg_prescan, seg_black, seg_active} == 3'b000, "R11", "flags in reset",
        {seg_prescan, seg_black, seg_active}, 0);
    chk({hclk1, hclk2} == 2'b01, "R11", "hclk in reset", {hclk1, hclk2}, 1);
    chk(rgate == 1'b0, "R11", "rgate in reset", rgate, 0);
    chk(vclk == REST, "R11", "vclk in reset", vclk, REST);
  endtask

  task automatic t_sync;
    logic prev = 1'b0;
    int guard = 0;
    rst_n = 1'b1;
    while (!(hsync && !prev) && guard < 3 * L) begin
      prev = hsync;
      @(negedge clk);
      guard++;
    end
    chk(hsync == 1'b1, "R1", "first sync rise", hsync, 1);
  endtask

  initial begin
    xfer_mode = 2'b00;
    t_reset();
    t_sync();
    // Standard line; mode changed mid-line to double, must not apply (R10).
    check_line(0, "R6", 2'b01, 1000);
    // Double line; change to triple between edges at 300 must not apply (R7, R10).
    check_line(1, "R7", 2'b10, 300);
    // Triple line; change to 2'b11 early in blanking (R8, R10).
    check_line(2, "R8", 2'b11, 100);
    // Mode 2'b11 acts as standard (R10).
    check_line(0, "R10", 2'b01, 2000);
    check_line(1, "R7", 2'b01, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule